// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is the timing engine of a two-stage watchdog. A register front end hands it an enable level, a free-run select, a prescale select, an interrupt kind, a reboot-enable bit, two preload values and a single-cycle keep-alive pulse. The core itself keeps the stage, the prescaler and the down counter. Stage one counts the first preload down and ends with an interrupt of the selected kind. Stage two then counts the second preload down. What happens when stage two ends depends on the configuration: a reset request, a fresh stage one, or a halt.

The core runs from a fixed base clock, nominally 33 MHz. Each preload count lasts either 2^SLOW_SHIFT base cycles (slow mode, 2^15 by default) or 2^FAST_SHIFT base cycles (fast mode, 2^5 by default). Every event output is a one-cycle pulse, and the front end reacts to it. When the reset request is raised, the front end is expected to set its configuration back to defaults, which drops the enable. The previous-timeout pulse tells the front end to set its sticky flag.

Top module: `wdg_core`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, every output is 0.
- R2: The first edge at which enable_i is sampled high after being low starts stage one with the first preload. The stage-two indication then rises exactly max(P1,1) prescale periods after that edge.
- R3: A prescale period is 2^FAST_SHIFT base cycles when fast_scale_i is 1 and 2^SLOW_SHIFT base cycles when it is 0.
- R4: When stage one ends, stage2_o rises in the same cycle and a one-cycle pulse reports the interrupt. irq_kind_i 0 or 1 pulses irq_o. Kind 2 pulses smi_o. Kind 3 pulses neither.
- R5: Stage two lasts max(P2,1) prescale periods. If reboot_en_i is 1 when it ends, reset_req_o and prev_timeout_set_o pulse together for one cycle and running_o falls. Keep-alives are then ignored until enable_i has been low.
- R6: If stage two ends with reboot_en_i 0 and free_run_i 1, the core returns to stage one with the first preload, keeps running_o high and requests no reset.
- R7: If stage two ends with reboot_en_i 0 and free_run_i 0, the core halts with running_o and stage2_o both 0. A later keep-alive starts stage one again.
- R8: A keep-alive sampled while enabled reloads the first preload, clears the prescaler and forces stage one, whether the core was in stage one or in stage two.
- R9: While enable_i is low, running_o is 0, no pulse is produced and keep-alives have no effect.
- R10: A keep-alive on the same edge as a stage expiry wins. No pulse is produced and stage one restarts from that edge.
- R11: A preload of 0 lasts one prescale period, the same as a preload of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Watchdog enable level |
| free_run_i | input | 1 | Restart stage one after a non-rebooting stage-two expiry |
| fast_scale_i | input | 1 | 1 selects the short prescale period |
| irq_kind_i | input | 2 | Interrupt kind at stage-one expiry (0/1 normal, 2 SMI, 3 none) |
| reboot_en_i | input | 1 | Request reset at stage-two expiry |
| preload1_i | input | CNT_W | Stage-one count |
| preload2_i | input | CNT_W | Stage-two count |
| kick_i | input | 1 | Keep-alive pulse |
| irq_o | output | 1 | Normal interrupt pulse |
| smi_o | output | 1 | SMI pulse |
| reset_req_o | output | 1 | Reset request pulse |
| prev_timeout_set_o | output | 1 | Set pulse for the previous-timeout flag |
| stage2_o | output | 1 | Core is counting stage two |
| running_o | output | 1 | Core is counting either stage |

## Verification
The hardest case to reach from the ports is a keep-alive that lands on the exact edge where a stage expires. Reaching it needs an exact prediction of the expiry cycle. The bench computes that edge from the preload and the prescale and raises the keep-alive in the half cycle before it. It then confirms that no pulse appears and that a full stage one follows from that edge. The small configuration (4-bit preloads, 16- and 4-cycle periods) keeps the bench short enough to sweep every pair of preloads in fast mode and a diagonal of pairs in slow mode, so that off-by-one errors in either stage length show up.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ONE   = 3'd1,
        PH_TWO   = 3'd2,
        PH_HALT  = 3'd3,
        PH_SPENT = 3'd4
    } phase_e;

    localparam logic [1:0] KIND_SMI  = 2'd2;
    localparam logic [1:0] KIND_NONE = 2'd3;

    typedef struct packed {
        phase_e phase;
        logic   en_prev;
        logic   irq;
        logic   smi;
        logic   rst_req;
        logic   prev_set;
    } core_st_t;

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam logic [SLOW_SHIFT-1:0] SLOW_MASK = '1;
    localparam logic [SLOW_SHIFT-1:0] FAST_MASK =
        SLOW_SHIFT'((64'd1 << FAST_SHIFT) - 64'd1);

    logic [SLOW_SHIFT-1:0] pre_d, pre_q, mask;

    // The phase counter wraps freely; a period ends when the selected
    // low bits are all ones, so no reset on tick is needed.
    always_comb begin
        mask  = fast_i ? FAST_MASK : SLOW_MASK;
        pre_d = pre_q;
        if (clear_i) begin
            pre_d = '0;
        end else if (run_i) begin
            pre_d = pre_q + SLOW_SHIFT'(1);
        end
    end

    assign tick_o = run_i && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q > ONE)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    // Zero and one both mean "this period is the final one".
    assign last_o = (cnt_q <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             free_run_i,
    input  logic             fast_scale_i,
    input  logic [1:0]       irq_kind_i,
    input  logic             reboot_en_i,
    input  logic [CNT_W-1:0] preload1_i,
    input  logic [CNT_W-1:0] preload2_i,
    input  logic             kick_i,
    output logic             irq_o,
    output logic             smi_o,
    output logic             reset_req_o,
    output logic             prev_timeout_set_o,
    output logic             stage2_o,
    output logic             running_o
);
    core_st_t         st_d, st_q;
    logic             tick, last, expire;
    logic             start, restart;
    logic             load, clr_pre, run;
    logic [CNT_W-1:0] load_val;

    assign run = (st_q.phase == PH_ONE) || (st_q.phase == PH_TWO);

    wdg_prescale #(
        .SLOW_SHIFT (SLOW_SHIFT),
        .FAST_SHIFT (FAST_SHIFT)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr_pre),
        .run_i   (run),
        .fast_i  (fast_scale_i),
        .tick_o  (tick)
    );

    wdg_downcount #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick),
        .last_o     (last)
    );

    always_comb begin
        st_d          = st_q;
        st_d.en_prev  = enable_i;
        st_d.irq      = 1'b0;
        st_d.smi      = 1'b0;
        st_d.rst_req  = 1'b0;
        st_d.prev_set = 1'b0;
        load          = 1'b0;
        clr_pre       = 1'b0;
        load_val      = preload1_i;
        start         = enable_i && !st_q.en_prev;
        restart       = enable_i && kick_i && (st_q.phase != PH_SPENT);
        expire        = tick && last;

        if (!enable_i) begin
            st_d.phase = PH_IDLE;
        end else if (start || restart) begin
            // start or keep-alive outranks an expiry on the same edge
            st_d.phase = PH_ONE;
            load       = 1'b1;
            clr_pre    = 1'b1;
        end else if (expire) begin
            case (st_q.phase)
                PH_ONE: begin
                    st_d.phase = PH_TWO;
                    load       = 1'b1;
                    load_val   = preload2_i;
                    st_d.irq   = !irq_kind_i[1];
                    st_d.smi   = (irq_kind_i == KIND_SMI);
                end
                PH_TWO: begin
                    if (reboot_en_i) begin
                        st_d.phase    = PH_SPENT;
                        st_d.rst_req  = 1'b1;
                        st_d.prev_set = 1'b1;
                    end else if (free_run_i) begin
                        st_d.phase = PH_ONE;
                        load       = 1'b1;
                    end else begin
                        st_d.phase = PH_HALT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, en_prev: 1'b0, irq: 1'b0,
                      smi: 1'b0, rst_req: 1'b0, prev_set: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o              = st_q.irq;
    assign smi_o              = st_q.smi;
    assign reset_req_o        = st_q.rst_req;
    assign prev_timeout_set_o = st_q.prev_set;
    assign stage2_o           = (st_q.phase == PH_TWO);
    assign running_o          = run;
endmodule

// File: rtl/wdg_core_chk.sv
module wdg_core_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic [1:0]       irq_kind_i,
    input logic             kick_i,
    input logic [CNT_W-1:0] preload1_i,
    input logic             irq_o,
    input logic             smi_o,
    input logic             reset_req_o,
    input logic             prev_timeout_set_o,
    input logic             stage2_o,
    input logic             running_o
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R4
    AST_SMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |=> !smi_o); // R4
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, smi_o, reset_req_o})); // R4
    AST_IRQ_ENTERS_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || smi_o) |-> stage2_o); // R4
    AST_RESET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> (prev_timeout_set_o && !running_o)); // R5
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!running_o && !irq_o && !smi_o && !reset_req_o)); // R9
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && enable_i && running_o) |=>
        (running_o && !stage2_o && !irq_o && !smi_o && !reset_req_o)); // R10
endmodule

bind wdg_core wdg_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .enable_i           (enable_i),
    .irq_kind_i         (irq_kind_i),
    .kick_i             (kick_i),
    .preload1_i         (preload1_i),
    .irq_o              (irq_o),
    .smi_o              (smi_o),
    .reset_req_o        (reset_req_o),
    .prev_timeout_set_o (prev_timeout_set_o),
    .stage2_o           (stage2_o),
    .running_o          (running_o)
);

// File: tb/sim_wdg_core.sv
`timescale 1ns/1ps
module sim_wdg_core;
    localparam int CW = 4;
    localparam int SS = 4;
    localparam int FS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable_i = 1'b0, free_run_i = 1'b0, fast_scale_i = 1'b0;
    logic [1:0]    irq_kind_i = 2'd0;
    logic          reboot_en_i = 1'b0, kick_i = 1'b0;
    logic [CW-1:0] preload1_i = '0, preload2_i = '0;
    logic          irq_o, smi_o, reset_req_o, prev_timeout_set_o, stage2_o, running_o;

    int n_cmp = 0;
    int n_bad = 0;
    int edge_cnt = 0;

    always #5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    wdg_core #(.CNT_W(CW), .SLOW_SHIFT(SS), .FAST_SHIFT(FS)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .free_run_i(free_run_i),
        .fast_scale_i(fast_scale_i), .irq_kind_i(irq_kind_i), .reboot_en_i(reboot_en_i),
        .preload1_i(preload1_i), .preload2_i(preload2_i), .kick_i(kick_i),
        .irq_o(irq_o), .smi_o(smi_o), .reset_req_o(reset_req_o),
        .prev_timeout_set_o(prev_timeout_set_o), .stage2_o(stage2_o), .running_o(running_o)
    );

    function automatic int per(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int plen(input int fast);
        return fast != 0 ? (1 << FS) : (1 << SS);
    endfunction

    function automatic int kind_bits(input int kind);
        if (kind < 2) return 2;
        if (kind == 2) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (edge_cnt < t) @(negedge clk);
    endtask

    task automatic start_run(input int fast, input int p1, input int p2, input int kind,
                             input int reboot, input int free, output int t0);
        @(negedge clk);
        enable_i     = 1'b0;
        kick_i       = 1'b0;
        fast_scale_i = fast[0];
        preload1_i   = CW'(p1);
        preload2_i   = CW'(p2);
        irq_kind_i   = kind[1:0];
        reboot_en_i  = reboot[0];
        free_run_i   = free[0];
        @(negedge clk);
        @(negedge clk);
        enable_i = 1'b1;
        t0 = edge_cnt + 1;
    endtask

    task automatic stage1_end(input int t0, input int p1, input int kind, input int L,
                              output int tend);
        tend = t0 + per(p1) * L;
        wait_to(tend - 1);
        chk("R2 stage one still counting", {31'd0, stage2_o}, 0);
        chk("R2 running during stage one", {31'd0, running_o}, 1);
        wait_to(tend);
        chk("R2 R3 stage one length", {31'd0, stage2_o}, 1);
        chk("R4 interrupt kind pulse", {30'd0, irq_o, smi_o}, kind_bits(kind));
        wait_to(tend + 1);
        chk("R4 interrupt pulse one cycle", {30'd0, irq_o, smi_o}, 0);
    endtask

    task automatic stage2_end(input int ts, input int p2, input int L, output int tend);
        tend = ts + per(p2) * L;
        wait_to(tend - 1);
        chk("R5 stage two still counting", {31'd0, stage2_o}, 1);
        chk("R5 no early reset request", {31'd0, reset_req_o}, 0);
        wait_to(tend);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: bench hung actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int t0, t1, t2, tk;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {26'd0, irq_o, smi_o, reset_req_o, prev_timeout_set_o,
            stage2_o, running_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {26'd0, irq_o, smi_o, reset_req_o, prev_timeout_set_o,
            stage2_o, running_o}, 0);

        // R2 R3 R5 R11: every preload pair in fast mode, a diagonal in slow mode
        for (int f = 1; f >= 0; f--) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    if (f == 0 && b != 15 - a) continue;
                    start_run(f, a, b, 0, 1, 0, t0);
                    stage1_end(t0, a, 0, plen(f), t1);
                    stage2_end(t1, b, plen(f), t2);
                    chk("R5 reset request pulse", {30'd0, reset_req_o, prev_timeout_set_o}, 3);
                    chk("R5 stopped after reset request", {31'd0, running_o}, 0);
                    wait_to(t2 + 1);
                    chk("R5 reset request one cycle", {30'd0, reset_req_o, prev_timeout_set_o}, 0);
                end
            end
        end

        // R4: every interrupt kind
        for (int k = 0; k < 4; k++) begin
            start_run(1, 2, 1, k, 1, 0, t0);
            stage1_end(t0, 2, k, 4, t1);
        end

        // R11: preload 0 equals one period in both stages
        start_run(1, 0, 0, 0, 1, 0, t0);
        wait_to(t0 + 4);
        chk("R11 zero preload stage one", {31'd0, stage2_o}, 1);
        wait_to(t0 + 8);
        chk("R11 zero preload stage two", {31'd0, reset_req_o}, 1);

        // R5: keep-alive ignored after reboot expiry until enable drops
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        chk("R5 kick ignored after reset request", {31'd0, running_o}, 0);

        // R6: free run returns to stage one
        start_run(1, 2, 3, 0, 0, 1, t0);
        stage1_end(t0, 2, 0, 4, t1);
        stage2_end(t1, 3, 4, t2);
        chk("R6 free run back in stage one", {29'd0, running_o, stage2_o, reset_req_o}, 4);
        stage1_end(t2, 2, 0, 4, t1);

        // R7: halt, then keep-alive restarts
        start_run(1, 1, 2, 0, 0, 0, t0);
        stage1_end(t0, 1, 0, 4, t1);
        stage2_end(t1, 2, 4, t2);
        chk("R7 halted", {29'd0, running_o, stage2_o, reset_req_o}, 0);
        repeat (10) @(negedge clk);
        chk("R7 stays halted", {30'd0, running_o, irq_o}, 0);
        kick_i = 1'b1;
        tk = edge_cnt + 1;
        wait_to(tk);
        kick_i = 1'b0;
        chk("R7 kick restarts", {31'd0, running_o}, 1);
        stage1_end(tk, 1, 0, 4, t1);

        // R8: keep-alive during stage two
        start_run(1, 1, 5, 0, 1, 0, t0);
        stage1_end(t0, 1, 0, 4, t1);
        wait_to(t1 + 6);
        kick_i = 1'b1;
        tk = edge_cnt + 1;
        wait_to(tk);
        kick_i = 1'b0;
        chk("R8 kick forces stage one", {30'd0, running_o, stage2_o}, 2);
        stage1_end(tk, 1, 0, 4, t1);

        // R8: keep-alive in mid stage one delays expiry
        start_run(1, 3, 1, 0, 1, 0, t0);
        wait_to(t0 + 7);
        kick_i = 1'b1;
        tk = edge_cnt + 1;
        wait_to(tk);
        kick_i = 1'b0;
        stage1_end(tk, 3, 0, 4, t1);

        // R10: keep-alive on the exact expiry edge
        start_run(1, 3, 1, 2, 1, 0, t0);
        wait_to(t0 + 11);
        kick_i = 1'b1;
        wait_to(t0 + 12);
        kick_i = 1'b0;
        chk("R10 no pulse on coincident kick", {29'd0, irq_o, smi_o, stage2_o}, 0);
        chk("R10 still running", {31'd0, running_o}, 1);
        stage1_end(t0 + 12, 3, 2, 4, t1);

        // R9: disable stops counting, kicks ignored
        start_run(1, 2, 2, 0, 1, 0, t0);
        wait_to(t0 + 3);
        enable_i = 1'b0;
        wait_to(t0 + 4);
        chk("R9 disabled stops", {31'd0, running_o}, 0);
        kick_i = 1'b1;
        wait_to(t0 + 6);
        kick_i = 1'b0;
        chk("R9 kick ignored while disabled", {31'd0, running_o}, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq_o || smi_o || reset_req_o || prev_timeout_set_o)
                chk("R9 no pulse while disabled", 1, 0);
        end
        chk("R9 quiet while disabled", {28'd0, irq_o, smi_o, reset_req_o, running_o}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule